// File: doc/BRIEF.md
# Used-Ring Completion and Interrupt Gate

This block hands finished requests back to a driver through a shared-memory used ring and decides whether the driver gets an interrupt. Each completion command stores a used element (head descriptor index and total byte count) in the slot chosen by a local used counter modulo the ring depth, then advances that counter. Nothing becomes visible to the driver until a sync command writes the counter into the used-index field. The sync then reads the driver's available-ring flags and applies the interrupt policy.

The policy raises the queue interrupt when the driver has not asked for silence. It also raises it when the driver asked for silence, but the notify-on-empty feature was negotiated and the queue is empty. Raised and suppressed decisions each have an event counter. Two further commands set or clear the no-notify flag in the used-ring flag word by read-modify-write, leaving its other bits intact. A single memory port carries one transaction at a time, in program order.

Top module: `used_ring_gate`

## Requirements
- R1: After reset, `irq` is low, `isr` is zero, both event counters are zero, `cmd_ready` is high and `mem_req` is low.
- R2: A completion (`cmd_op` = 2'b00) writes the zero-extended head index as a 32-bit word at `used_base + 4 + 8*(n mod DEPTH)`, where n is the local used count. It then writes the 32-bit length at that address + 4, and n increments by one.
- R3: A sync (`cmd_op` = 2'b01) first writes n as a 16-bit value at `used_base + 2`. Only after that write is acknowledged does it issue a 16-bit read of the available flags at `avail_base`.
- R4: When bit 0 of the returned available flags is 0, the sync sets `isr` bit 0, drives `irq` high and increments `cnt_raised` by one.
- R5: When bit 0 of the flags is 1 but `feat_notify_empty` and `queue_empty` are both high on the cycle the flags return, the sync still raises (same effects as R4).
- R6: Otherwise the sync increments `cnt_skipped` by one and leaves `irq` and `isr` unchanged.
- R7: `cmd_op` = 2'b10 (enable notify) and 2'b11 (disable notify) do a 16-bit read at `used_base`. They then write back the same value with bit 0 cleared (enable) or set (disable), and all other bits are preserved.
- R8: At most one memory transaction is outstanding. While `mem_req` is high and unacknowledged, the address, data, direction and size stay stable.
- R9: A pulse on `isr_clr` clears `isr` and drops `irq`.
- R10: A command is taken only while `cmd_ready` is high. `cmd_valid` raised while a command is in progress causes no memory traffic and no state change.
- R11: The used slot wraps. The completion with count DEPTH reuses slot 0, and the next one reuses slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| used_base | input | AW | Byte address of the used ring |
| avail_base | input | AW | Byte address of the available-ring flag word |
| feat_notify_empty | input | 1 | Notify-on-empty feature negotiated |
| queue_empty | input | 1 | Queue currently has no pending entries |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 complete, 01 sync, 10 notify on, 11 notify off |
| cmd_head | input | 16 | Head descriptor index for a completion |
| cmd_len | input | 32 | Total length for a completion |
| cmd_ready | output | 1 | Idle, able to take a command |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | 1 for 32-bit, 0 for 16-bit access (low half) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transaction done; read data valid |
| mem_rdata | input | 32 | Read data (16-bit reads in low half) |
| isr_clr | input | 1 | Clear interrupt status and line |
| isr | output | 8 | Interrupt cause bits; bit 0 is the queue cause |
| irq | output | 1 | Interrupt line |
| cnt_raised | output | CNT_W | Raised-interrupt count |
| cnt_skipped | output | CNT_W | Suppressed-interrupt count |

## Verification
The bench aims at the three ways the notify decision can go. A wrong polarity of the no-interrupt bit, or ignoring the notify-on-empty rule, would show up as interrupts raised while the driver asked for silence, or as missing ones. Slot wrap after the ring depth is exercised. A design that fails to take the modulo would write past the ring, where the bench memory model finds foreign addresses. Write order is compared transaction by transaction, so an index published before its element, or a flags read ahead of the index write, is reported. The read-modify-write is checked with the other flag bits set, so a design that writes a constant would clobber them.

// File: rtl/used_ring_gate.sv
module used_ring_gate #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    used_base,
  input  logic [AW-1:0]    avail_base,
  input  logic             feat_notify_empty,
  input  logic             queue_empty,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [15:0]      cmd_head,
  input  logic [31:0]      cmd_len,
  output logic             cmd_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_wide,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  input  logic             isr_clr,
  output logic [7:0]       isr,
  output logic             irq,
  output logic [CNT_W-1:0] cnt_raised,
  output logic [CNT_W-1:0] cnt_skipped
);

  localparam logic [15:0] DEPTH16 = 16'(DEPTH);

  typedef enum logic [2:0] {
    S_IDLE, S_ID, S_LEN, S_IDX, S_FLG, S_RD, S_WR
  } state_t;

  state_t      state;
  logic [1:0]  op_q;
  logic [15:0] head_q;
  logic [31:0] len_q;
  logic [15:0] used_cnt;
  logic [15:0] rmw_q;
  logic [AW-1:0] elem_addr;
  logic        raise_now, skip_now;

  assign cmd_ready = (state == S_IDLE);
  assign mem_req   = (state != S_IDLE);
  assign elem_addr = used_base + AW'(4) + (AW'(used_cnt % DEPTH16) << 3);
  assign raise_now = (state == S_FLG) && mem_ack &&
                     (!mem_rdata[0] || (feat_notify_empty && queue_empty));
  assign skip_now  = (state == S_FLG) && mem_ack && !raise_now;

  always_comb begin
    mem_we    = 1'b0;
    mem_wide  = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_ID:  begin mem_we = 1'b1; mem_wide = 1'b1; mem_addr = elem_addr;          mem_wdata = {16'h0, head_q}; end
      S_LEN: begin mem_we = 1'b1; mem_wide = 1'b1; mem_addr = elem_addr + AW'(4); mem_wdata = len_q; end
      S_IDX: begin mem_we = 1'b1; mem_addr = used_base + AW'(2); mem_wdata = {16'h0, used_cnt}; end
      S_FLG: mem_addr = avail_base;
      S_RD:  mem_addr = used_base;
      S_WR:  begin mem_we = 1'b1; mem_addr = used_base; mem_wdata = {16'h0, rmw_q[15:1], op_q[0]}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      head_q   <= '0;
      len_q    <= '0;
      used_cnt <= '0;
      rmw_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          head_q <= cmd_head;
          len_q  <= cmd_len;
          case (cmd_op)
            2'b00:   state <= S_ID;
            2'b01:   state <= S_IDX;
            default: state <= S_RD;
          endcase
        end
        S_ID:  if (mem_ack) state <= S_LEN;
        S_LEN: if (mem_ack) begin
          used_cnt <= used_cnt + 16'd1;
          state    <= S_IDLE;
        end
        S_IDX: if (mem_ack) state <= S_FLG;
        S_FLG: if (mem_ack) state <= S_IDLE;
        S_RD:  if (mem_ack) begin
          rmw_q <= mem_rdata[15:0];
          state <= S_WR;
        end
        S_WR:  if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr         <= '0;
      irq         <= 1'b0;
      cnt_raised  <= '0;
      cnt_skipped <= '0;
    end else begin
      if (raise_now) begin
        isr[0]     <= 1'b1;
        irq        <= 1'b1;
        cnt_raised <= cnt_raised + CNT_W'(1);
      end else if (isr_clr) begin
        isr <= '0;
        irq <= 1'b0;
      end
      if (skip_now) cnt_skipped <= cnt_skipped + CNT_W'(1);
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                            && $stable(mem_we) && $stable(mem_wide));

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> mem_req);

  // R4
  raise_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cnt_raised == $past(cnt_raised) + CNT_W'(1) && isr[0]);

  // R6
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_skipped != $past(cnt_skipped) && !$past(isr_clr) |-> $stable(irq) && $stable(isr));

  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_clr |=> (cnt_raised != $past(cnt_raised)) || (!irq && isr == 8'h00));

endmodule

// File: tb/used_ring_gate_tb_top.sv
module used_ring_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam logic [31:0] UB = 32'h200;
  localparam logic [31:0] AB = 32'h080;

  logic clk = 0, rst_n = 0;
  logic feat_notify_empty = 0, queue_empty = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [15:0] cmd_head = 0;
  logic [31:0] cmd_len = 0;
  logic cmd_ready, mem_req, mem_we, mem_wide;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = 0;
  logic isr_clr = 0;
  logic [7:0] isr;
  logic irq;
  logic [15:0] cnt_raised, cnt_skipped;

  always #(CLK_PERIOD/2) clk = ~clk;

  used_ring_gate #(.AW(32), .DEPTH(DEPTH), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .used_base(UB), .avail_base(AB),
    .feat_notify_empty(feat_notify_empty), .queue_empty(queue_empty),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_head(cmd_head), .cmd_len(cmd_len),
    .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .isr_clr(isr_clr), .isr(isr), .irq(irq),
    .cnt_raised(cnt_raised), .cnt_skipped(cnt_skipped));

  typedef struct packed {
    logic        we;
    logic        wide;
    logic [31:0] addr;
    logic [31:0] data;
  } txn_t;

  txn_t exp_q[$];
  int   tag_q[$];
  logic [7:0] mem [0:1023];
  int n_chk = 0, n_fail = 0;
  int wcnt = 0, lat = 0;

  int m_used = 0, m_raised = 0, m_skipped = 0;
  logic m_irq = 0;
  logic [7:0] m_isr = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd16(logic [31:0] a);
    return {mem[a[9:0]+10'd1], mem[a[9:0]]};
  endfunction
  function automatic logic [31:0] rd32(logic [31:0] a);
    return {rd16(a + 32'd2), rd16(a)};
  endfunction
  task automatic wr16(logic [31:0] a, logic [15:0] d);
    mem[a[9:0]] = d[7:0];
    mem[a[9:0]+10'd1] = d[15:8];
  endtask

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        txn_t e;
        int t;
        wcnt = 0;
        lat = (lat + 1) % 3;
        if (exp_q.size() == 0) begin
          check("R10 unexpected transaction", mem_addr, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check($sformatf("R%0d txn addr", t), mem_addr, e.addr);
          check($sformatf("R%0d txn dir/size", t), {30'h0, mem_we, mem_wide}, {30'h0, e.we, e.wide});
          if (e.we) check($sformatf("R%0d txn data", t), mem_wdata, e.data);
        end
        if (mem_we) begin
          mem[mem_addr[9:0]] = mem_wdata[7:0];
          mem[mem_addr[9:0]+10'd1] = mem_wdata[15:8];
          if (mem_wide) begin
            mem[mem_addr[9:0]+10'd2] = mem_wdata[23:16];
            mem[mem_addr[9:0]+10'd3] = mem_wdata[31:24];
          end
        end else mem_rdata = {16'h0, rd16(mem_addr)};
        mem_ack = 1'b1;
      end
    end
  end

  task automatic push(logic we, logic wide, logic [31:0] a, logic [31:0] d, int tag);
    txn_t e;
    e.we = we; e.wide = wide; e.addr = a; e.data = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run_cmd(logic [1:0] op, logic [15:0] head, logic [31:0] len, bit poke_busy);
    logic [31:0] ea;
    while (!cmd_ready) @(negedge clk);
    case (op)
      2'b00: begin
        ea = UB + 32'd4 + 32'(8 * (m_used % DEPTH));
        push(1, 1, ea, {16'h0, head}, 2);
        push(1, 1, ea + 32'd4, len, 2);
        m_used = (m_used + 1) % 65536;
      end
      2'b01: begin
        push(1, 0, UB + 32'd2, 32'(m_used), 3);
        push(0, 0, AB, 32'h0, 3);
        if (!rd16(AB)[0] || (feat_notify_empty && queue_empty)) begin
          m_raised++; m_irq = 1; m_isr[0] = 1;
        end else m_skipped++;
      end
      default: begin
        push(0, 0, UB, 32'h0, 7);
        push(1, 0, UB, {16'h0, rd16(UB)[15:1], op[0]}, 7);
      end
    endcase
    cmd_valid = 1; cmd_op = op; cmd_head = head; cmd_len = len;
    @(negedge clk);
    cmd_valid = 0;
    if (poke_busy) begin
      cmd_valid = 1; cmd_op = 2'b01;
      @(negedge clk);
      cmd_valid = 0;
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic cmp_state(string tag);
    check({tag, " irq"}, {31'h0, irq}, {31'h0, m_irq});
    check({tag, " isr"}, {24'h0, isr}, {24'h0, m_isr});
    check({tag, " raised"}, {16'h0, cnt_raised}, 32'(m_raised));
    check({tag, " skipped"}, {16'h0, cnt_skipped}, 32'(m_skipped));
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'h0, irq}, 0);
    check("R1 isr", {24'h0, isr}, 0);
    check("R1 counters", {cnt_raised, cnt_skipped}, 0);
    check("R1 idle", {30'h0, cmd_ready, mem_req}, 32'h2);
    rst_n = 1;
    @(negedge clk);

    // R2 completions, R3 + R4 sync with no-interrupt bit clear
    wr16(AB, 16'h0000);
    run_cmd(2'b00, 16'h0011, 32'd100, 0);
    run_cmd(2'b00, 16'h0022, 32'd200, 0);
    run_cmd(2'b00, 16'h0033, 32'd300, 0);
    check("R2 elem1 id", rd32(UB + 32'd12), 32'h22);
    check("R2 elem1 len", rd32(UB + 32'd16), 32'd200);
    run_cmd(2'b01, 0, 0, 0);
    check("R3 used idx", {16'h0, rd16(UB + 32'd2)}, 32'd3);
    cmp_state("R4");

    // R9 clear
    isr_clr = 1; @(negedge clk); isr_clr = 0; @(negedge clk);
    m_irq = 0; m_isr = 0;
    cmp_state("R9");

    // R6 suppressed
    wr16(AB, 16'h0001);
    run_cmd(2'b01, 0, 0, 0);
    cmp_state("R6 no feature");
    feat_notify_empty = 1; queue_empty = 0;
    run_cmd(2'b01, 0, 0, 0);
    cmp_state("R6 not empty");
    feat_notify_empty = 0; queue_empty = 1;
    run_cmd(2'b01, 0, 0, 0);
    cmp_state("R6 empty without feature");

    // R5 notify on empty
    feat_notify_empty = 1; queue_empty = 1;
    run_cmd(2'b01, 0, 0, 0);
    cmp_state("R5");

    // R7 notify flag read-modify-write
    wr16(UB, 16'hA5A4);
    run_cmd(2'b11, 0, 0, 0);
    check("R7 disable", {16'h0, rd16(UB)}, 32'hA5A5);
    run_cmd(2'b10, 0, 0, 0);
    check("R7 enable", {16'h0, rd16(UB)}, 32'hA5A4);

    // R11 wrap past the ring depth
    for (int k = 0; k < 7; k++) run_cmd(2'b00, 16'(16'h0100 + k), 32'(1000 + k), 0);
    check("R11 slot0 id", rd32(UB + 32'd4), 32'h0105);
    check("R11 slot1 id", rd32(UB + 32'd12), 32'h0106);
    check("R11 slot1 len", rd32(UB + 32'd16), 32'd1006);

    // R10 command during busy ignored
    run_cmd(2'b00, 16'h0777, 32'd77, 1);
    check("R10 queue drained", 32'(exp_q.size()), 0);
    cmp_state("R10");
    wr16(AB, 16'h0000);
    run_cmd(2'b01, 0, 0, 0);
    check("R10 used idx", {16'h0, rd16(UB + 32'd2)}, 32'd11);
    cmp_state("R4 second raise");

    repeat (4) @(negedge clk);
    // R8 every expected transaction seen once, in order
    check("R8 all transactions", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule